// File: doc/BRIEF.md
# Multi-Unicast Destination Enumerator

This block turns a broadcast request into a stream of unicast destinations. A request carries a 256-bit target vector, a 15-bit starting node ID, a flag that selects the tree-structured multicast format, and the subnode ID that every destination must be addressed to. When the flag is clear, the vector is a flat list: bit `i` set means node `start + i` is a target. The block walks the vector from the lowest set bit to the highest and hands each target node out on a valid/ready stream, one per accepted transfer.

The number of targets (the number of set bits) is available the cycle after the request is taken, before the first destination is handed out. This lets the sender size its acknowledgement bookkeeping up front. A one-cycle done pulse marks the end of every request. Requests that use the tree format, or that name a subnode other than the local-block subnode 0x10, are refused with an error flag and produce no destinations.

Top module: `dest_enum`

## Requirements
- R1: After synchronous reset, `dst_valid_o`, `done_o` and `busy_o` are low, `total_o` is 0 and both error flags are low.
- R2: Destinations are emitted in ascending bit order, and the node ID for bit `i` is the latched start ID plus `i`.
- R3: The node ID sum wraps modulo 2^15. For example, start 0x7FFF with bit 1 gives node 0x0000.
- R4: `total_o` equals the number of set bits in the accepted vector. It is valid from the cycle after the load and is held until the next accepted load.
- R5: Each accepted transfer (`dst_valid_o` and `dst_ready_i` both high at a clock edge) consumes exactly one destination. While `dst_ready_i` is low, `dst_valid_o` stays high and `dst_node_o` holds its value.
- R6: `done_o` is high for exactly one cycle, in the cycle after the final transfer. In that cycle `busy_o` and `dst_valid_o` are low.
- R7: An all-zero vector gives `done_o` in the cycle after the load, with `total_o` = 0 and no destination emitted.
- R8: A load with `tree_mode_i` = 1 sets `err_tree_o`, emits nothing, reports `total_o` = 0 and pulses `done_o` in the cycle after the load.
- R9: Every emitted destination carries subnode 0x10 on `dst_sub_o`. A load whose `sub_i` is not 0x10 sets `err_sub_o`, emits nothing, reports `total_o` = 0 and pulses `done_o` in the cycle after the load.
- R10: A load strobe that arrives while `busy_o` is high is ignored. The ongoing sequence and `total_o` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Request strobe, taken only while idle |
| targets_i | input | 256 | Target vector, bit i means node start+i |
| start_i | input | 15 | Node ID that bit 0 maps to |
| tree_mode_i | input | 1 | Tree-structured multicast format (unsupported) |
| sub_i | input | 6 | Subnode ID requested by the sender |
| busy_o | output | 1 | A sequence is in progress |
| dst_valid_o | output | 1 | A destination is presented |
| dst_ready_i | input | 1 | Consumer accepts the presented destination |
| dst_node_o | output | 15 | Destination node ID |
| dst_sub_o | output | 6 | Destination subnode ID |
| done_o | output | 1 | One-cycle end-of-request pulse |
| total_o | output | 9 | Number of destinations of the last accepted request |
| err_tree_o | output | 1 | Last request used the tree format |
| err_sub_o | output | 1 | Last request named a wrong subnode |

## Verification
The bench targets the ends of the vector: bit 0 alone, bit 255 together with bit 0, and a fully set vector of 256 targets. These catch an off-by-one in the scan or a count that is one bit too narrow, which would drop the last destination or report 0 instead of 256. Start IDs near 0x7FFF check the wrap. A design that carried the sum into a 16th bit, or saturated it, would produce wrong node IDs at the top of the range. Consumer stalls check that a destination is not consumed twice or skipped while ready is low. Zero vectors, refused requests and a load strobe arriving mid-sequence check that the done pulse comes exactly once and that a stray load neither restarts the walk nor overwrites the count.

// File: rtl/dest_enum_pkg.sv
package dest_enum_pkg;

    localparam int DE_VEC_W  = 256;
    localparam int DE_NODE_W = 15;
    localparam int DE_SUB_W  = 6;
    localparam logic [DE_SUB_W-1:0] DE_LOCAL_SUB = 6'h10;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

    // Outcome of checking an incoming request.
    typedef struct packed {
        logic tree_bad;
        logic sub_bad;
    } req_check_t;

    function automatic req_check_t check_request(input logic tree_mode,
                                                 input logic [DE_SUB_W-1:0] sub);
        req_check_t r;
        r.tree_bad = tree_mode;
        r.sub_bad  = (sub != DE_LOCAL_SUB);
        return r;
    endfunction

endpackage

// File: rtl/dest_popcount.sv
module dest_popcount #(
    parameter int W     = 256,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     bits_i,
    output logic [CNT_W-1:0] ones_o
);
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CNT_W'(bits_i[i]);
        end
    end
endmodule

// File: rtl/dest_lowest_set.sv
module dest_lowest_set #(
    parameter int W     = 256,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     mask_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [W-1:0]     rest_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IDX_W'(i);
        end
        found_o = |mask_i;
        rest_o  = mask_i;
        rest_o[idx_o] = 1'b0;
    end
endmodule

// File: rtl/dest_enum.sv
module dest_enum
    import dest_enum_pkg::*;
#(
    parameter int VEC_W  = DE_VEC_W,
    parameter int NODE_W = DE_NODE_W,
    parameter int SUB_W  = DE_SUB_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load_i,
    input  logic [VEC_W-1:0]               targets_i,
    input  logic [NODE_W-1:0]              start_i,
    input  logic                           tree_mode_i,
    input  logic [SUB_W-1:0]               sub_i,
    output logic                           busy_o,
    output logic                           dst_valid_o,
    input  logic                           dst_ready_i,
    output logic [NODE_W-1:0]              dst_node_o,
    output logic [SUB_W-1:0]               dst_sub_o,
    output logic                           done_o,
    output logic [$clog2(VEC_W+1)-1:0]     total_o,
    output logic                           err_tree_o,
    output logic                           err_sub_o
);
    localparam int CNT_W = $clog2(VEC_W + 1);
    localparam int IDX_W = $clog2(VEC_W);

    walk_state_e        state_q;
    logic [VEC_W-1:0]   mask_q;
    logic [NODE_W-1:0]  start_q;
    logic [CNT_W-1:0]   total_q;
    logic               done_q;
    logic               err_tree_q;
    logic               err_sub_q;

    logic [CNT_W-1:0]   in_ones;
    logic               found;
    logic [IDX_W-1:0]   low_idx;
    logic [VEC_W-1:0]   mask_rest;
    req_check_t         chk;
    logic               take_load;
    logic               xfer;

    dest_popcount #(.W(VEC_W), .CNT_W(CNT_W)) u_count (
        .bits_i (targets_i),
        .ones_o (in_ones)
    );

    dest_lowest_set #(.W(VEC_W), .IDX_W(IDX_W)) u_scan (
        .mask_i  (mask_q),
        .found_o (found),
        .idx_o   (low_idx),
        .rest_o  (mask_rest)
    );

    assign chk       = check_request(tree_mode_i, sub_i);
    assign take_load = load_i && (state_q == ST_IDLE);
    assign xfer      = dst_valid_o && dst_ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            mask_q     <= '0;
            start_q    <= '0;
            total_q    <= '0;
            done_q     <= 1'b0;
            err_tree_q <= 1'b0;
            err_sub_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (take_load) begin
                start_q    <= start_i;
                err_tree_q <= chk.tree_bad;
                err_sub_q  <= chk.sub_bad;
                if (!chk.tree_bad && !chk.sub_bad) begin
                    mask_q  <= targets_i;
                    total_q <= in_ones;
                    if (|targets_i) begin
                        state_q <= ST_WALK;
                    end else begin
                        done_q  <= 1'b1;
                    end
                end else begin
                    mask_q  <= '0;
                    total_q <= '0;
                    done_q  <= 1'b1;
                end
            end else if (state_q == ST_WALK && xfer) begin
                mask_q <= mask_rest;
                if (mask_rest == '0) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign busy_o      = (state_q == ST_WALK);
    assign dst_valid_o = (state_q == ST_WALK) && found;
    assign dst_node_o  = start_q + NODE_W'(low_idx);
    assign dst_sub_o   = DE_LOCAL_SUB;
    assign done_o      = done_q;
    assign total_o     = total_q;
    assign err_tree_o  = err_tree_q;
    assign err_sub_o   = err_sub_q;

    // Assertions

    // R5: a stalled destination is held steady
    p_hold_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (dst_valid_o && !dst_ready_i) |=> (dst_valid_o && $stable(dst_node_o)));

    // R5: each transfer removes exactly one target from the pending set
    p_one_per_xfer_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && xfer && !load_i) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

    // R6: done is a single-cycle pulse, issued while idle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !dst_valid_o));

    // R8: refused tree-format request never emits
    p_tree_silent_r8: assert property (@(posedge clk) disable iff (rst)
        err_tree_o |-> !dst_valid_o);

    // R9: emitted destinations always target the local subnode
    p_sub_local_r9: assert property (@(posedge clk) disable iff (rst)
        dst_valid_o |-> (dst_sub_o == 6'h10));

    // R10: a load during a walk leaves the count alone
    p_busy_load_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && load_i) |=> $stable(total_o));

endmodule

// File: tb/tb_dest_enum.sv
module tb_dest_enum;

    localparam int VW = 256;
    localparam int NW = 15;
    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_i;
    logic [VW-1:0] targets_i;
    logic [NW-1:0] start_i;
    logic          tree_mode_i;
    logic [SW-1:0] sub_i;
    logic          busy_o;
    logic          dst_valid_o;
    logic          dst_ready_i;
    logic [NW-1:0] dst_node_o;
    logic [SW-1:0] dst_sub_o;
    logic          done_o;
    logic [8:0]    total_o;
    logic          err_tree_o;
    logic          err_sub_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dest_enum dut (
        .clk(clk), .rst(rst), .load_i(load_i), .targets_i(targets_i),
        .start_i(start_i), .tree_mode_i(tree_mode_i), .sub_i(sub_i),
        .busy_o(busy_o), .dst_valid_o(dst_valid_o), .dst_ready_i(dst_ready_i),
        .dst_node_o(dst_node_o), .dst_sub_o(dst_sub_o), .done_o(done_o),
        .total_o(total_o), .err_tree_o(err_tree_o), .err_sub_o(err_sub_o)
    );

    // Stimulus / expected table: vector, start, expected count, expected first node
    localparam int NCASE = 5;
    localparam logic [VW-1:0] T_VEC [NCASE] = '{
        256'h1,
        {1'b1, 254'b0, 1'b1},
        256'hF0,
        256'hAAAA,
        {VW{1'b1}}
    };
    localparam logic [NW-1:0] T_START [NCASE] = '{15'd100, 15'h7F80, 15'd5, 15'h7FFF, 15'd42};
    localparam int T_CNT   [NCASE] = '{1, 2, 4, 8, 256};
    localparam int T_FIRST [NCASE] = '{100, 32640, 9, 0, 42};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [VW-1:0] v, input logic [NW-1:0] s,
                           input logic tm, input logic [SW-1:0] sb);
        targets_i = v; start_i = s; tree_mode_i = tm; sub_i = sb; load_i = 1'b1;
        cyc();
        load_i = 1'b0;
    endtask

    // Walks the whole stream of a loaded vector, stalling every third item.
    task automatic drain(input logic [VW-1:0] v, input logic [NW-1:0] s, input int first_exp);
        int k = 0;
        for (int i = 0; i < VW; i++) begin
            if (v[i]) begin
                int exp_node = (int'(s) + i) % 32768;
                if (k == 0) chk(exp_node == first_exp, "R3 table first node", exp_node, first_exp);
                if (k % 3 == 1) begin
                    dst_ready_i = 1'b0;
                    cyc();
                    chk(dst_valid_o && int'(dst_node_o) == exp_node, "R5 stall hold",
                        int'(dst_node_o), exp_node);
                end
                dst_ready_i = 1'b1;
                chk(dst_valid_o && int'(dst_node_o) == exp_node, "R2 node order",
                    int'(dst_node_o), exp_node);
                chk(dst_sub_o == 6'h10, "R9 subnode", int'(dst_sub_o), 16);
                chk(!done_o, "R6 no early done", int'(done_o), 0);
                cyc();
                dst_ready_i = 1'b0;
                k++;
            end
        end
        chk(done_o && !busy_o && !dst_valid_o, "R6 done after last", int'(done_o), 1);
        cyc();
        chk(!done_o, "R6 done one cycle", int'(done_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_i = 1'b0; targets_i = '0; start_i = '0;
        tree_mode_i = 1'b0; sub_i = 6'h10; dst_ready_i = 1'b0;
        @(negedge clk);
        cyc(); cyc();
        rst = 1'b0;
        // R1 reset state
        chk(!dst_valid_o && !done_o && !busy_o, "R1 outputs idle", int'(busy_o), 0);
        chk(total_o == 0 && !err_tree_o && !err_sub_o, "R1 count/errors", int'(total_o), 0);
        cyc();

        // Table walk
        for (int c = 0; c < NCASE; c++) begin
            do_load(T_VEC[c], T_START[c], 1'b0, 6'h10);
            chk(int'(total_o) == T_CNT[c], "R4 count", int'(total_o), T_CNT[c]);
            chk(busy_o && !err_tree_o && !err_sub_o, "R4 busy after load", int'(busy_o), 1);
            drain(T_VEC[c], T_START[c], T_FIRST[c]);
            chk(int'(total_o) == T_CNT[c], "R4 count held", int'(total_o), T_CNT[c]);
        end

        // R7 all-zero vector
        do_load('0, 15'd7, 1'b0, 6'h10);
        chk(done_o && !dst_valid_o && !busy_o, "R7 zero done", int'(done_o), 1);
        chk(total_o == 0, "R7 zero count", int'(total_o), 0);
        cyc();
        chk(!done_o && !dst_valid_o, "R7 quiet after", int'(done_o), 0);

        // R8 tree format refused
        do_load(256'hFF, 15'd1, 1'b1, 6'h10);
        chk(err_tree_o && done_o && !dst_valid_o, "R8 tree refused", int'(err_tree_o), 1);
        chk(total_o == 0, "R8 count zero", int'(total_o), 0);
        cyc();
        chk(!dst_valid_o && !busy_o, "R8 nothing emitted", int'(dst_valid_o), 0);

        // R9 wrong subnode refused
        do_load(256'h3, 15'd1, 1'b0, 6'h11);
        chk(err_sub_o && !err_tree_o && done_o && !dst_valid_o, "R9 sub refused", int'(err_sub_o), 1);
        chk(total_o == 0, "R9 count zero", int'(total_o), 0);
        cyc();
        chk(!dst_valid_o && !busy_o, "R9 nothing emitted", int'(dst_valid_o), 0);

        // R10 load while busy is ignored
        do_load((256'b1 << 2) | (256'b1 << 9), 15'd1000, 1'b0, 6'h10);
        chk(!err_sub_o && total_o == 2, "R10 count", int'(total_o), 2);
        dst_ready_i = 1'b1;
        chk(int'(dst_node_o) == 1002, "R10 first", int'(dst_node_o), 1002);
        cyc();
        dst_ready_i = 1'b0;
        targets_i = {VW{1'b1}}; start_i = 15'd0; load_i = 1'b1;
        cyc();
        load_i = 1'b0;
        chk(dst_valid_o && int'(dst_node_o) == 1009, "R10 walk intact", int'(dst_node_o), 1009);
        chk(total_o == 2, "R10 count intact", int'(total_o), 2);
        dst_ready_i = 1'b1;
        cyc();
        dst_ready_i = 1'b0;
        chk(done_o && !busy_o, "R10 done", int'(done_o), 1);
        cyc();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule